// File: doc/BRIEF.md
# Differential PWM Channel Modulator

This block turns one signed audio sample per PWM period into a pair of pulse-width-modulated outputs, plus and minus, for a single channel of a switching amplifier. Time is counted in oversampling clock periods (one per `clk` edge). A period is 2^CNT_W clocks long, 256 by default. Each pulse is centred in its period.

Three modulation schemes are available:
- Complementary (AD): the minus output is the inverse of the plus output.
- Bridged (BD): the two outputs carry mirrored widths.
- Ternary: only one output pulses, chosen by the sign of the sample. The ternary enable takes priority over the bridged select.

A coded limit sets a minimum pulse width, which bounds the modulation index. A per-channel start delay staggers the first edge after the channel leaves mute. Two conditions force a hard mute in which neither output switches: a mute input, or a back-end fault input held low for long enough.

The sample, the scheme and the limit code are captured only when a new period starts. Changes applied mid-period therefore never distort the running pulse.

Top module: `diff_pwm_channel`

## Requirements
- R1: Complementary mode (ternEn=0, bdSel=0): the plus width is w = clamp(128+x), where x is the sample. The pulse starts at position (256−w)>>1 of the period, and the minus output is the inverse of plus throughout a running period.
- R2: Bridged mode (ternEn=0, bdSel=1): plus has width clamp(128+x) and minus has width clamp(128−x). Each pulse starts at position (256−width)>>1.
- R3: Ternary mode (ternEn=1, regardless of bdSel): for x>0 plus has width 2x and minus stays low. For x<0 minus has width −2x and plus stays low. For x=0 both outputs stay low. Widths are capped at 256 minus the minimum width, centred as in R2, and the two outputs are never high together.
- R4: With limit code c, the minimum width is 2(c+1) clocks. In complementary and bridged modes every width is clamped to the range [2(c+1), 256−2(c+1)]; x=0 gives exactly 50% duty.
- R5: Sample, scheme bits and limit code are captured at the last clock of a period (and when running starts). A change made mid-period affects only the following period.
- R6: With start delay D, if mute is released before rising edge E0, both outputs stay low through edge E0+D. Period position 0 appears on the outputs after edge E0+D+1.
- R7: When hardMute is high at a rising edge, both outputs are low after that edge and stay low while it remains high. Release restarts the period from position 0 after the start delay.
- R8: bkndErrN low at ERR_CYC (5) consecutive rising edges mutes the channel: the outputs go low at the next edge. A shorter low pulse has no effect on the outputs.
- R9: During and after reset, with mute held, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, one DCLK per edge |
| rstN | input | 1 | Active-low asynchronous reset |
| hardMute | input | 1 | Forces the non-switching mute state |
| bkndErrN | input | 1 | Active-low back-end fault, filtered over ERR_CYC clocks |
| ternEn | input | 1 | Selects ternary modulation; overrides bdSel |
| bdSel | input | 1 | 1 = bridged, 0 = complementary (when ternEn=0) |
| limCode | input | LIM_W | Minimum-width code, width = 2(code+1) |
| startDelay | input | DLY_W | Clocks of quiet delay after leaving mute |
| sample | input | CNT_W | Signed audio sample |
| pwmP | output | 1 | Plus PWM output |
| pwmM | output | 1 | Minus PWM output |

## Verification
The bench targets each clamp edge separately:
- Full positive and full negative samples in complementary and bridged modes, and the ternary −128 case. A design missing the clamp would emit a 255-, 0- or 256-clock pulse instead of the limited one.
- An odd width (x = −7). An off-by-one centring would shift the first high position.

Mid-period changes of sample, scheme and limit code check the capture timing. A design that captured them immediately would distort the period still running.

The start delay is measured to the exact clock against a pulse that is high at position 0.

On the fault input, a four-clock low glitch must leave the period untouched. A five-clock low must mute on exactly the following edge.

// File: rtl/diff_pwm_pkg.sv
package diff_pwm_pkg;

  typedef enum logic [1:0] {
    MOD_AD   = 2'd0,
    MOD_BD   = 2'd1,
    MOD_TERN = 2'd2
  } mod_e;

  typedef enum logic [1:0] {
    ST_MUTE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } ctrl_st_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;   // outputs may switch this clock
    logic load;  // capture a new sample/config for the next period
  } pwm_strobe_t;

endpackage

// File: rtl/diff_pwm_ctrl.sv
module diff_pwm_ctrl
  import diff_pwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DLY_W   = 8,
  parameter int ERR_CYC = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hardMute,
  input  logic              bkndErrN,
  input  logic [DLY_W-1:0]  startDelay,
  output pwm_strobe_t       strobe,
  output logic [CNT_W-1:0]  cnt
);

  localparam int ERR_W = $clog2(ERR_CYC + 1);
  localparam logic [ERR_W-1:0] ERR_LIM  = ERR_W'(ERR_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  ctrl_st_e         state;
  logic [DLY_W-1:0] dlyCnt;
  logic [ERR_W-1:0] errCnt;
  logic             stopNow;
  logic             delayDone;

  // fault filter: saturating count of consecutive low samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt <= '0;
    end else if (bkndErrN) begin
      errCnt <= '0;
    end else if (errCnt != ERR_LIM) begin
      errCnt <= errCnt + 1'b1;
    end
  end

  assign stopNow   = hardMute || (errCnt == ERR_LIM);
  assign delayDone = (dlyCnt >= startDelay);

  always_comb begin
    strobe.run  = (state == ST_RUN) && !stopNow;
    strobe.load = 1'b0;
    if (!stopNow) begin
      case (state)
        ST_MUTE:  strobe.load = (startDelay == '0);
        ST_DELAY: strobe.load = delayDone;
        ST_RUN:   strobe.load = (cnt == CNT_LAST);
        default:  strobe.load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_MUTE;
      cnt    <= '0;
      dlyCnt <= '0;
    end else if (stopNow) begin
      state  <= ST_MUTE;
      cnt    <= '0;
      dlyCnt <= '0;
    end else begin
      case (state)
        ST_MUTE: begin
          cnt <= '0;
          if (startDelay == '0) begin
            state <= ST_RUN;
          end else begin
            state  <= ST_DELAY;
            dlyCnt <= DLY_W'(1);
          end
        end
        ST_DELAY: begin
          if (delayDone) begin
            state <= ST_RUN;
            cnt   <= '0;
          end else begin
            dlyCnt <= dlyCnt + 1'b1;
          end
        end
        ST_RUN:  cnt <= cnt + 1'b1;
        default: state <= ST_MUTE;
      endcase
    end
  end

endmodule

// File: rtl/diff_pwm_dp.sv
module diff_pwm_dp
  import diff_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LIM_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pwm_strobe_t             strobe,
  input  logic [CNT_W-1:0]        cnt,
  input  logic signed [CNT_W-1:0] sample,
  input  logic                    ternEn,
  input  logic                    bdSel,
  input  logic [LIM_W-1:0]        limCode,
  output logic                    pwmP,
  output logic                    pwmM,
  output mod_e                    actMode
);

  localparam int WW     = CNT_W + 2;
  localparam int PERIOD = 1 << CNT_W;
  localparam int HALF   = PERIOD / 2;
  localparam int NLEG   = 2;

  typedef logic signed [WW-1:0] sw_t;

  localparam sw_t PERIOD_W = sw_t'(PERIOD);
  localparam sw_t HALF_W   = sw_t'(HALF);

  function automatic sw_t clampW(sw_t v, sw_t lo, sw_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  mod_e          modeNext;
  mod_e          modeQ;
  sw_t           sx, minW, maxW, mag, twin;
  sw_t           wNext [NLEG];
  logic [NLEG-1:0] legOn;
  logic [WW-1:0] cntW;

  assign modeNext = ternEn ? MOD_TERN : (bdSel ? MOD_BD : MOD_AD);
  assign sx       = sw_t'(sample);
  assign minW     = (sw_t'(limCode) + sw_t'(1)) <<< 1;
  assign maxW     = PERIOD_W - minW;
  assign mag      = (sx < 0) ? -sx : sx;
  assign twin     = (mag <<< 1);
  assign cntW     = {2'b00, cnt};

  always_comb begin
    case (modeNext)
      MOD_BD: begin
        wNext[0] = clampW(HALF_W + sx, minW, maxW);
        wNext[1] = clampW(HALF_W - sx, minW, maxW);
      end
      MOD_TERN: begin
        wNext[0] = (sx > 0) ? ((twin > maxW) ? maxW : twin) : sw_t'(0);
        wNext[1] = (sx < 0) ? ((twin > maxW) ? maxW : twin) : sw_t'(0);
      end
      default: begin
        wNext[0] = clampW(HALF_W + sx, minW, maxW);
        wNext[1] = wNext[0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MOD_AD;
    end else if (strobe.load) begin
      modeQ <= modeNext;
    end
  end

  // one width/start register pair and one window comparator per leg
  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic [WW-1:0] wQ;
    logic [WW-1:0] loQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wQ  <= '0;
        loQ <= '0;
      end else if (strobe.load) begin
        wQ  <= wNext[g];
        loQ <= (PERIOD_W - wNext[g]) >>> 1;
      end
    end

    assign legOn[g] = (cntW >= loQ) && (cntW < (loQ + wQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmP <= 1'b0;
      pwmM <= 1'b0;
    end else begin
      pwmP <= strobe.run && legOn[0];
      pwmM <= strobe.run && ((modeQ == MOD_AD) ? !legOn[0] : legOn[1]);
    end
  end

  assign actMode = modeQ;

endmodule

// File: rtl/diff_pwm_channel.sv
module diff_pwm_channel
  import diff_pwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DLY_W   = 8,
  parameter int LIM_W   = 4,
  parameter int ERR_CYC = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hardMute,
  input  logic                    bkndErrN,
  input  logic                    ternEn,
  input  logic                    bdSel,
  input  logic [LIM_W-1:0]        limCode,
  input  logic [DLY_W-1:0]        startDelay,
  input  logic signed [CNT_W-1:0] sample,
  output logic                    pwmP,
  output logic                    pwmM
);

  pwm_strobe_t      strobe;
  logic [CNT_W-1:0] cnt;
  mod_e             actMode;

  diff_pwm_ctrl #(
    .CNT_W  (CNT_W),
    .DLY_W  (DLY_W),
    .ERR_CYC(ERR_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hardMute  (hardMute),
    .bkndErrN  (bkndErrN),
    .startDelay(startDelay),
    .strobe    (strobe),
    .cnt       (cnt)
  );

  diff_pwm_dp #(
    .CNT_W(CNT_W),
    .LIM_W(LIM_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cnt    (cnt),
    .sample (sample),
    .ternEn (ternEn),
    .bdSel  (bdSel),
    .limCode(limCode),
    .pwmP   (pwmP),
    .pwmM   (pwmM),
    .actMode(actMode)
  );

endmodule

// File: rtl/diff_pwm_channel_sva.sv
module diff_pwm_channel_sva
  import diff_pwm_pkg::*;
#(
  parameter int ERR_CYC = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        hardMute,
  input logic        bkndErrN,
  input logic        pwmP,
  input logic        pwmM,
  input pwm_strobe_t strobe,
  input mod_e        actMode
);

  localparam int LW = $clog2(ERR_CYC + 1);
  localparam logic [LW-1:0] LOW_LIM = LW'(ERR_CYC);

  logic [LW-1:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowRun <= '0;
    else if (bkndErrN)         lowRun <= '0;
    else if (lowRun != LOW_LIM) lowRun <= lowRun + 1'b1;
  end

  assert_mute_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    hardMute |=> (!pwmP && !pwmM));

  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lowRun == LOW_LIM) |=> (!pwmP && !pwmM));

  assert_ad_complement_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && actMode == MOD_AD) |=> (pwmP != pwmM));

  assert_tern_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && actMode == MOD_TERN) |=> !(pwmP && pwmM));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (!pwmP && !pwmM));

endmodule

bind diff_pwm_channel diff_pwm_channel_sva #(.ERR_CYC(ERR_CYC)) u_sva (
  .clk     (clk),
  .rstN    (rstN),
  .hardMute(hardMute),
  .bkndErrN(bkndErrN),
  .pwmP    (pwmP),
  .pwmM    (pwmM),
  .strobe  (strobe),
  .actMode (actMode)
);

// File: tb/diff_pwm_channel_bench.sv
module diff_pwm_channel_bench;

  logic              clk = 1'b0;
  logic              rstN;
  logic              hardMute;
  logic              bkndErrN;
  logic              ternEn;
  logic              bdSel;
  logic [3:0]        limCode;
  logic [7:0]        startDelay;
  logic signed [7:0] sample;
  logic              pwmP;
  logic              pwmM;

  always #2 clk = ~clk;

  diff_pwm_channel u_diff_pwm_channel (
    .clk(clk), .rstN(rstN), .hardMute(hardMute), .bkndErrN(bkndErrN),
    .ternEn(ternEn), .bdSel(bdSel), .limCode(limCode),
    .startDelay(startDelay), .sample(sample), .pwmP(pwmP), .pwmM(pwmM)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string tag;
    int    pCnt;
    int    pFirst;
    int    mCnt;
    int    mFirst;
  } exp_t;

  exp_t expQ[$];

  task automatic checkEq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int clampI(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // width model from the requirements; -1 marks "complement of plus"
  function automatic int legWidth(int leg, int x, bit tern, bit bd, int code);
    int mn = 2 * (code + 1);
    int mx = 256 - mn;
    if (tern) begin
      if (leg == 0) return (x > 0) ? ((2 * x > mx) ? mx : 2 * x) : 0;
      return (x < 0) ? ((-2 * x > mx) ? mx : -2 * x) : 0;
    end
    if (leg == 0) return clampI(128 + x, mn, mx);
    return bd ? clampI(128 - x, mn, mx) : -1;
  endfunction

  function automatic bit inWin(int pos, int w);
    int lo = (256 - w) / 2;
    return (pos >= lo) && (pos < lo + w);
  endfunction

  task automatic pushExp(string tag, int x, bit tern, bit bd, int code);
    exp_t e;
    int wp = legWidth(0, x, tern, bd, code);
    int wm = legWidth(1, x, tern, bd, code);
    e.tag = tag; e.pCnt = 0; e.mCnt = 0; e.pFirst = -1; e.mFirst = -1;
    for (int pos = 0; pos < 256; pos++) begin
      bit p = inWin(pos, wp);
      bit m = (wm < 0) ? !p : inWin(pos, wm);
      if (p) begin e.pCnt++; if (e.pFirst < 0) e.pFirst = pos; end
      if (m) begin e.mCnt++; if (e.mFirst < 0) e.mFirst = pos; end
    end
    expQ.push_back(e);
  endtask

  // monitor one period; optionally change inputs mid-period or glitch the fault pin
  task automatic measure(bit chg, int nx, bit nt, bit nb, int nc, int glitch);
    exp_t e;
    int pc = 0, mc = 0, pf = -1, mf = -1;
    for (int pos = 0; pos < 256; pos++) begin
      @(negedge clk);
      if (pwmP) begin pc++; if (pf < 0) pf = pos; end
      if (pwmM) begin mc++; if (mf < 0) mf = pos; end
      if (chg && pos == 100) begin
        sample = 8'(nx); ternEn = nt; bdSel = nb; limCode = 4'(nc);
      end
      if (glitch > 0 && pos == 150)          bkndErrN = 1'b0;
      if (glitch > 0 && pos == 150 + glitch) bkndErrN = 1'b1;
    end
    e = expQ.pop_front();
    checkEq(e.tag, "plus width", pc, e.pCnt);
    checkEq(e.tag, "plus first", pf, e.pFirst);
    checkEq(e.tag, "minus width", mc, e.mCnt);
    checkEq(e.tag, "minus first", mf, e.mFirst);
  endtask

  task automatic expectQuiet(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkEq(tag, "outputs low", int'(pwmP) + int'(pwmM), 0);
    end
  endtask

  initial begin
    #80000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hardMute = 1'b1; bkndErrN = 1'b1;
    ternEn = 1'b0; bdSel = 1'b0; limCode = '0; startDelay = '0; sample = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expectQuiet("R9", 6);

    // release mute, no delay, complementary, x=0
    @(negedge clk);
    hardMute = 1'b0;
    @(posedge clk); @(posedge clk);

    pushExp("R4", 0, 0, 0, 0);       // 50% duty
    measure(1, 100, 0, 0, 0, 0);
    pushExp("R5", 100, 0, 0, 0);     // change at pos 100 seen only now
    measure(1, 127, 0, 0, 0, 0);
    pushExp("R4", 127, 0, 0, 0);     // clamp to 254
    measure(1, -128, 0, 0, 0, 0);
    pushExp("R4", -128, 0, 0, 0);    // clamp to 2
    measure(1, -128, 0, 0, 3, 0);
    pushExp("R4", -128, 0, 0, 3);    // clamp to 8
    measure(1, 50, 0, 1, 0, 0);
    pushExp("R2", 50, 0, 1, 0);
    measure(1, -128, 0, 1, 0, 0);
    pushExp("R2", -128, 0, 1, 0);    // plus 2, minus 254
    measure(1, 40, 1, 1, 0, 0);
    pushExp("R3", 40, 1, 1, 0);      // ternary overrides bdSel
    measure(1, -128, 1, 0, 1, 0);
    pushExp("R3", -128, 1, 0, 1);    // minus capped at 252
    measure(1, 0, 1, 0, 0, 0);
    pushExp("R3", 0, 1, 0, 0);       // both idle
    measure(1, -7, 0, 0, 0, 0);
    pushExp("R1", -7, 0, 0, 0);      // odd width 121
    measure(0, 0, 0, 0, 0, 0);

    // hard mute, then staggered restart
    hardMute = 1'b1;
    expectQuiet("R7", 30);
    startDelay = 8'd37;
    hardMute = 1'b0;
    @(posedge clk);
    expectQuiet("R6", 38);
    pushExp("R6", -7, 0, 0, 0);
    measure(0, 0, 0, 0, 0, 0);

    // short fault glitch has no effect
    pushExp("R8", -7, 0, 0, 0);
    measure(0, 0, 0, 0, 0, 4);

    // sustained fault
    bkndErrN = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    checkEq("R8", "running before filter expires", int'(pwmP ^ pwmM), 1);
    @(negedge clk);
    checkEq("R8", "outputs low after fault", int'(pwmP) + int'(pwmM), 0);
    expectQuiet("R8", 20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule